// File: doc/BRIEF.md
# Display Memory Clear and Reset Sequencer

This block re-initialises the display memories of a character display controller. It responds to two triggers. The first is a software clear, started by writing a control word with its clear bit set. The second is the external active-low reset pin. Either trigger runs a fixed sequence of clock cycles. In every cycle of that sequence, one wide parallel write port loads the blank code 20h into all character entries and 0 into all flash entries.

The two paths keep different state. A software clear leaves the rest of the control word as it was written, and the clear bit drops by itself when the clear ends. A reset zeroes the whole control word. Neither path writes the user-defined-character address register.

While either sequence runs, the block raises a busy flag and discards every host write. While the reset pin is low, the block also gates host writes directly from that pin. The character and flash memories sit outside the block and take the write ports it drives. Host writes are level-qualified by chip enable and write strobe (both active low). The host target and entry index are decoded inside the block.

Top module: `disp_clear_seq`

## Requirements
- R1: While `rst_n` is low, `busy` is 1, `ctrl_word` is 0 and `udc_addr_we` is 0, even when `ce_n`, `wr_n` and a target are driven, and all bits of `char_we` and `flash_we` are 1.
- R2: After `rst_n` rises, `busy` stays high for SYNC_STAGES + SEQ_CYCLES rising clock edges (2 + 3 with defaults), then drops.
- R3: In every cycle with `busy` high, all `char_we` bits are 1 with every byte of `char_wdata` equal to 20h, and all `flash_we` bits are 1 with `flash_wdata` all zero.
- R4: A control-word write (`host_tgt` = 0) with bit 7 set, made while idle, raises `busy` at that clock edge and holds it for exactly SEQ_CYCLES cycles.
- R5: During a clear, `ctrl_word` holds the written value with bit 7 at 1. When `busy` drops, bit 7 is 0 and the other bits keep the written value.
- R6: Host writes to any target while `busy` is high are ignored: `ctrl_word` does not change, `udc_addr_we` stays 0, and the character and flash ports carry only the blank pattern.
- R7: While idle, a write happens only when `ce_n` and `wr_n` are both 0 at a clock edge. Target 1 writes `host_data` to character entry `host_idx`. Target 2 writes `host_data` bit 0 to flash entry `host_idx`. Target 3 writes `host_data` to the user-defined-character address register. Only the addressed entry is enabled.
- R8: A control-word write with bit 7 clear updates `ctrl_word` at the next edge and does not raise `busy`.
- R9: Taking `rst_n` low during a clear abandons the clear at once: `ctrl_word` becomes 0, and the full reset sequence of R2 follows the release.
- R10: Neither sequence asserts `udc_addr_we`, so the user-defined-character address register keeps its value across clears and resets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | External reset, active low, asynchronous assert |
| ce_n | input | 1 | Chip enable, active low |
| wr_n | input | 1 | Write strobe, active low |
| host_tgt | input | 2 | Write target: 0 control word, 1 character RAM, 2 flash RAM, 3 user-defined-character address |
| host_idx | input | 3 | Entry index for character and flash targets |
| host_data | input | 8 | Host write data |
| char_we | output | 8 | Per-entry character RAM write enables |
| char_wdata | output | 64 | Character write data, entry i in bits [8i+7:8i] |
| flash_we | output | 8 | Per-entry flash RAM write enables |
| flash_wdata | output | 8 | Flash write data, entry i in bit i |
| udc_addr_we | output | 1 | User-defined-character address register write enable |
| udc_addr_wdata | output | 8 | User-defined-character address write data |
| ctrl_word | output | 8 | Control word register, bit 7 is the clear request |
| busy | output | 1 | Sequence in progress, host access refused |

## Verification
The bench uses the default parameters: eight entries of eight bits, three sequence cycles and a two-stage reset synchroniser. With eight entries, the whole character memory packs into one 64-bit value, so a single comparison after each sequence shows that every entry was blanked. The short windows of three and five cycles let the bench count the busy duration edge by edge. They also let it place ignored writes in specific cycles of a running clear, including a reset that cuts a clear short.

// File: rtl/disp_clr_pkg.sv
package disp_clr_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_RESET = 2'd1,
    SEQ_CLEAR = 2'd2
  } seq_state_e;

  typedef enum logic [1:0] {
    TGT_CTRL  = 2'd0,
    TGT_CHAR  = 2'd1,
    TGT_FLASH = 2'd2,
    TGT_UDCA  = 2'd3
  } host_tgt_e;

endpackage

// File: rtl/disp_rst_sync.sv
module disp_rst_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [SYNC_STAGES-1:0] sync_q;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_sync_n = sync_q[SYNC_STAGES-1];

endmodule

// File: rtl/disp_clr_fsm.sv
module disp_clr_fsm
  import disp_clr_pkg::*;
#(
  parameter int unsigned SEQ_CYCLES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic clr_done
);

  localparam int unsigned CNT_W = (SEQ_CYCLES > 1) ? $clog2(SEQ_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(SEQ_CYCLES - 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             last;

  assign last   = (cnt_q == LAST_CNT);
  assign cnt_en = (state_q != SEQ_IDLE);

  // next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      SEQ_IDLE: begin
        if (start) begin
          state_d = SEQ_CLEAR;
          cnt_d   = '0;
        end
      end
      default: begin
        if (last) begin
          state_d = SEQ_IDLE;
          cnt_d   = '0;
        end else begin
          cnt_d   = cnt_q + 1'b1;
        end
      end
    endcase
  end

  // registers: reset enters the reset sequence at step zero
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_RESET;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign busy     = (state_q != SEQ_IDLE);
  assign clr_done = (state_q == SEQ_CLEAR) && last;

endmodule

// File: rtl/disp_ctrl_reg.sv
module disp_ctrl_reg #(
  parameter int unsigned CHAR_W  = 8,
  parameter int unsigned CLR_BIT = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CHAR_W-1:0] wdata,
  input  logic              clr_done,
  output logic              start,
  output logic [CHAR_W-1:0] ctrl_q
);

  localparam logic [CHAR_W-1:0] CLR_MASK = CHAR_W'(1) << CLR_BIT;

  logic [CHAR_W-1:0] ctrl_d;
  logic              ctrl_en;

  assign ctrl_en = wr_en | clr_done;

  always_comb begin
    if (wr_en) ctrl_d = wdata;
    else       ctrl_d = ctrl_q & ~CLR_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_en) ctrl_q <= ctrl_d;
  end

  assign start = wr_en & wdata[CLR_BIT];

endmodule

// File: rtl/disp_wport.sv
module disp_wport #(
  parameter int unsigned N_ENTRIES  = 8,
  parameter int unsigned CHAR_W     = 8,
  parameter int unsigned BLANK_CODE = 32'h20
) (
  input  logic                          busy,
  input  logic                          wr_char,
  input  logic                          wr_flash,
  input  logic [$clog2(N_ENTRIES)-1:0]  idx,
  input  logic [CHAR_W-1:0]             data,
  output logic [N_ENTRIES-1:0]          char_we,
  output logic [N_ENTRIES*CHAR_W-1:0]   char_wdata,
  output logic [N_ENTRIES-1:0]          flash_we,
  output logic [N_ENTRIES-1:0]          flash_wdata
);

  localparam int unsigned IDX_W = $clog2(N_ENTRIES);
  localparam logic [CHAR_W-1:0] BLANK = CHAR_W'(BLANK_CODE);

  generate
    for (genvar i = 0; i < N_ENTRIES; i++) begin : g_entry
      logic hit;
      assign hit = (idx == IDX_W'(i));
      assign char_we[i]                   = busy | (wr_char & hit);
      assign char_wdata[i*CHAR_W +: CHAR_W] = busy ? BLANK : data;
      assign flash_we[i]                  = busy | (wr_flash & hit);
      assign flash_wdata[i]               = busy ? 1'b0 : data[0];
    end
  endgenerate

endmodule

// File: rtl/disp_clear_seq.sv
module disp_clear_seq
  import disp_clr_pkg::*;
#(
  parameter int unsigned N_ENTRIES   = 8,
  parameter int unsigned CHAR_W      = 8,
  parameter int unsigned SEQ_CYCLES  = 3,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CLR_BIT     = 7,
  parameter int unsigned BLANK_CODE  = 32'h20
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ce_n,
  input  logic                          wr_n,
  input  logic [1:0]                    host_tgt,
  input  logic [$clog2(N_ENTRIES)-1:0]  host_idx,
  input  logic [CHAR_W-1:0]             host_data,
  output logic [N_ENTRIES-1:0]          char_we,
  output logic [N_ENTRIES*CHAR_W-1:0]   char_wdata,
  output logic [N_ENTRIES-1:0]          flash_we,
  output logic [N_ENTRIES-1:0]          flash_wdata,
  output logic                          udc_addr_we,
  output logic [CHAR_W-1:0]             udc_addr_wdata,
  output logic [CHAR_W-1:0]             ctrl_word,
  output logic                          busy
);

  logic rst_sync_n;
  logic host_wr;
  logic wr_ctrl, wr_char, wr_flash;
  logic start, clr_done;

  disp_rst_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // reset pin gates host writes directly, busy covers the sequences
  assign host_wr  = rst_n & ~ce_n & ~wr_n & ~busy;
  assign wr_ctrl  = host_wr & (host_tgt == TGT_CTRL);
  assign wr_char  = host_wr & (host_tgt == TGT_CHAR);
  assign wr_flash = host_wr & (host_tgt == TGT_FLASH);

  assign udc_addr_we    = host_wr & (host_tgt == TGT_UDCA);
  assign udc_addr_wdata = host_data;

  disp_ctrl_reg #(.CHAR_W(CHAR_W), .CLR_BIT(CLR_BIT)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (wr_ctrl),
    .wdata    (host_data),
    .clr_done (clr_done),
    .start    (start),
    .ctrl_q   (ctrl_word)
  );

  disp_clr_fsm #(.SEQ_CYCLES(SEQ_CYCLES)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start    (start),
    .busy     (busy),
    .clr_done (clr_done)
  );

  disp_wport #(
    .N_ENTRIES  (N_ENTRIES),
    .CHAR_W     (CHAR_W),
    .BLANK_CODE (BLANK_CODE)
  ) u_wport (
    .busy        (busy),
    .wr_char     (wr_char),
    .wr_flash    (wr_flash),
    .idx         (host_idx),
    .data        (host_data),
    .char_we     (char_we),
    .char_wdata  (char_wdata),
    .flash_we    (flash_we),
    .flash_wdata (flash_wdata)
  );

endmodule

// File: rtl/disp_clear_seq_chk.sv
module disp_clear_seq_chk #(
  parameter int unsigned N_ENTRIES   = 8,
  parameter int unsigned CHAR_W      = 8,
  parameter int unsigned SEQ_CYCLES  = 3,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CLR_BIT     = 7,
  parameter int unsigned BLANK_CODE  = 32'h20
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        busy,
  input logic [CHAR_W-1:0]           ctrl_word,
  input logic [N_ENTRIES-1:0]        char_we,
  input logic [N_ENTRIES*CHAR_W-1:0] char_wdata,
  input logic [N_ENTRIES-1:0]        flash_we,
  input logic [N_ENTRIES-1:0]        flash_wdata,
  input logic                        udc_addr_we
);

  localparam int unsigned LIMIT = SEQ_CYCLES + SYNC_STAGES;
  localparam int unsigned RUN_W = $clog2(LIMIT + 1) + 1;
  localparam logic [CHAR_W-1:0] BLANK = CHAR_W'(BLANK_CODE);
  localparam logic [N_ENTRIES*CHAR_W-1:0] ALL_BLANK = {N_ENTRIES{BLANK}};

  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_q <= '0;
    else if (busy) run_q <= run_q + 1'b1;
    else           run_q <= '0;
  end

  // busy never outlasts synchroniser plus sequence
  p_busy_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_q < RUN_W'(LIMIT)));

  p_full_blank_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (&char_we && char_wdata == ALL_BLANK && &flash_we && flash_wdata == '0));

  p_clear_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> busy);

  p_ctrl_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(ctrl_word));

  p_self_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !ctrl_word[CLR_BIT]);

  p_udc_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !udc_addr_we);

endmodule

bind disp_clear_seq disp_clear_seq_chk #(
  .N_ENTRIES   (N_ENTRIES),
  .CHAR_W      (CHAR_W),
  .SEQ_CYCLES  (SEQ_CYCLES),
  .SYNC_STAGES (SYNC_STAGES),
  .CLR_BIT     (CLR_BIT),
  .BLANK_CODE  (BLANK_CODE)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .ctrl_word   (ctrl_word),
  .char_we     (char_we),
  .char_wdata  (char_wdata),
  .flash_we    (flash_we),
  .flash_wdata (flash_wdata),
  .udc_addr_we (udc_addr_we)
);

// File: tb/disp_clear_seq_tb.sv
`timescale 1ns/1ps
module disp_clear_seq_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ce_n, wr_n;
  logic [1:0]  host_tgt;
  logic [2:0]  host_idx;
  logic [7:0]  host_data;
  logic [7:0]  char_we;
  logic [63:0] char_wdata;
  logic [7:0]  flash_we;
  logic [7:0]  flash_wdata;
  logic        udc_addr_we;
  logic [7:0]  udc_addr_wdata;
  logic [7:0]  ctrl_word;
  logic        busy;

  int checks = 0;
  int errors = 0;

  logic [7:0] char_mem [8];
  logic [7:0] flash_mem;
  logic [7:0] udc_reg;

  always #5 clk = ~clk;

  disp_clear_seq u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .wr_n(wr_n),
    .host_tgt(host_tgt), .host_idx(host_idx), .host_data(host_data),
    .char_we(char_we), .char_wdata(char_wdata),
    .flash_we(flash_we), .flash_wdata(flash_wdata),
    .udc_addr_we(udc_addr_we), .udc_addr_wdata(udc_addr_wdata),
    .ctrl_word(ctrl_word), .busy(busy)
  );

  // external memories modelled in the bench, written from the ports
  always @(posedge clk) begin
    for (int i = 0; i < 8; i++) begin
      if (char_we[i])  char_mem[i]  <= char_wdata[i*8 +: 8];
      if (flash_we[i]) flash_mem[i] <= flash_wdata[i];
    end
    if (udc_addr_we) udc_reg <= udc_addr_wdata;
  end

  function automatic logic [63:0] char_flat();
    logic [63:0] v;
    for (int i = 0; i < 8; i++) v[i*8 +: 8] = char_mem[i];
    return v;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [1:0] tgt, input logic [2:0] idx, input logic [7:0] d);
    @(negedge clk);
    ce_n = 1'b0; wr_n = 1'b0; host_tgt = tgt; host_idx = idx; host_data = d;
    @(negedge clk);
    ce_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (busy && n < 50) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset_hold();
    int n;
    rst_n = 1'b0;
    ce_n = 1'b0; wr_n = 1'b0; host_tgt = 2'd3; host_data = 8'h55;
    repeat (3) @(negedge clk);
    check("R1 busy in reset", busy, 1);
    check("R1 ctrl in reset", ctrl_word, 0);
    check("R1 udc write blocked", udc_addr_we, 0);
    check("R1 char_we all", char_we, 8'hFF);
    check("R1 flash_we all", flash_we, 8'hFF);
    ce_n = 1'b1; wr_n = 1'b1;
    rst_n = 1'b1;
    count_busy(n);
    check("R2 reset busy length", n, 5);
    check("R3 char blank after reset", char_flat(), 64'h2020202020202020);
    check("R3 flash zero after reset", flash_mem, 0);
  endtask

  task automatic t_idle_writes();
    logic [63:0] exp;
    host_write(2'd1, 3'd3, 8'h41);
    host_write(2'd1, 3'd0, 8'h5A);
    host_write(2'd2, 3'd5, 8'h01);
    host_write(2'd3, 3'd0, 8'h1F);
    exp = 64'h2020202020202020;
    exp[3*8 +: 8] = 8'h41;
    exp[0 +: 8]   = 8'h5A;
    check("R7 char entries", char_flat(), exp);
    check("R7 flash entry", flash_mem, 8'h20);
    check("R7 udc addr", udc_reg, 8'h1F);
    @(negedge clk);
    ce_n = 1'b1; wr_n = 1'b0; host_tgt = 2'd3; host_data = 8'hEE;
    @(negedge clk);
    ce_n = 1'b0; wr_n = 1'b1;
    @(negedge clk);
    ce_n = 1'b1; wr_n = 1'b1;
    check("R7 no write without both strobes", udc_reg, 8'h1F);
  endtask

  task automatic t_ctrl_plain();
    host_write(2'd0, 3'd0, 8'h05);
    check("R8 ctrl value", ctrl_word, 8'h05);
    check("R8 not busy", busy, 0);
  endtask

  task automatic t_clear();
    int n;
    host_write(2'd0, 3'd0, 8'h85);
    check("R5 ctrl during clear", ctrl_word, 8'h85);
    count_busy(n);
    check("R4 clear busy length", n, 3);
    check("R5 bit7 self cleared", ctrl_word, 8'h05);
    check("R3 char blank after clear", char_flat(), 64'h2020202020202020);
    check("R3 flash zero after clear", flash_mem, 0);
    check("R10 udc kept by clear", udc_reg, 8'h1F);
  endtask

  task automatic t_busy_ignore();
    host_write(2'd1, 3'd2, 8'h33);
    host_write(2'd2, 3'd1, 8'h01);
    host_write(2'd0, 3'd0, 8'h86);
    ce_n = 1'b0; wr_n = 1'b0; host_tgt = 2'd0; host_data = 8'h3C;
    @(negedge clk);
    check("R6 ctrl write ignored", ctrl_word, 8'h86);
    host_tgt = 2'd3; host_data = 8'h99;
    #1;
    check("R6 udc we low in clear", udc_addr_we, 0);
    @(negedge clk);
    ce_n = 1'b1; wr_n = 1'b1;
    @(negedge clk);
    check("R6 idle after clear", busy, 0);
    check("R6 ctrl after clear", ctrl_word, 8'h06);
    check("R6 udc unchanged", udc_reg, 8'h1F);
    check("R6 char blank", char_flat(), 64'h2020202020202020);
  endtask

  task automatic t_reset_mid();
    int n;
    host_write(2'd0, 3'd0, 8'h81);
    rst_n = 1'b0;
    #1;
    check("R9 ctrl zero on abort", ctrl_word, 0);
    check("R9 busy on abort", busy, 1);
    @(negedge clk);
    rst_n = 1'b1;
    count_busy(n);
    check("R9 full reset after abort", n, 5);
    check("R9 ctrl zero after", ctrl_word, 0);
    check("R10 udc kept by reset", udc_reg, 8'h1F);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ce_n = 1'b1; wr_n = 1'b1;
    host_tgt = 2'd0; host_idx = 3'd0; host_data = 8'h00;
    t_reset_hold();
    t_idle_writes();
    t_ctrl_plain();
    t_clear();
    t_busy_ignore();
    t_reset_mid();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule